// File: doc/BRIEF.md
# Cache Port Request Issue Controller

This block sits between a pipeline memory stage and a cache port that may refuse a send and later signal that it can take one again. It takes one memory request at a time, classifies it as fetch, read, write, prefetch or write hint, and chooses the port command. Two request flags affect that choice: one marks a linked load or conditional store, and one marks an atomic swap. The block then drives the port, waits for the response and reports completion to the stage.

A refused send sets a port-blocked state. While that state is set, the block makes no send attempts. A retry strobe from the port clears the state, and the held request is then offered again unchanged. Some requests finish without using the port. A conditional store whose link check has already failed completes straight away and reports the failure. Prefetches and write hints also complete straight away. A request can be squashed before its send is accepted, which drops it at once. It can also be squashed while its response is outstanding: the late response is then swallowed and the slot freed. A response that takes more than one cycle raises a memory-stall indication until it arrives.

Top module: `cache_issue_ctl`

## Requirements
- R1: After reset the block is ready for a request, does not send, reports no completion and shows no memory stall.
- R2: The command offered on the port follows the latched request. Fetch (op 0) and read (op 1) give READ (0). Read with the lock flag gives LOCKED_READ (1). Write (op 2) gives WRITE (2). Write with the swap flag gives SWAP (3), and swap wins over the lock flag. Write with the lock flag and without swap gives COND_STORE (4).
- R3: If a send is offered while port accept is low, the request stays held and port-blocked is set. From the next cycle the send stays low until a retry arrives.
- R4: A retry clears port-blocked, and from the next cycle the held request is offered again with the same command and sequence number. A retry while the port is not blocked is illegal.
- R5: A send taken with port accept high makes the request pending. From the next cycle the send is low and there is no completion until a response arrives.
- R6: A write with the lock flag and without swap, whose link check input is low at acceptance, completes in the next cycle with the failure flag set and never drives the port.
- R7: A prefetch (op 3) or write hint (op 4) completes in the next cycle with the failure flag clear and never drives the port.
- R8: While pending without a response, the memory stall is raised from the second pending cycle onward. A response clears the stall and gives a one-cycle completion carrying the request's sequence number in the next cycle.
- R9: A squash before the send is accepted drops the request with no completion. A squash while pending makes the later response be dropped with no completion. Either way the block is ready again afterwards.
- R10: Only one request is held at a time. Ready is low while one is held, and requests presented then are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request presented (taken only when reqReady is high) |
| reqOp | input | 3 | Request kind: 0 fetch, 1 read, 2 write, 3 prefetch, 4 write hint |
| reqLock | input | 1 | Linked-load / conditional-store flag |
| reqSwap | input | 1 | Atomic swap flag |
| reqSeq | input | SEQ_W | Request sequence number |
| linkOk | input | 1 | Result of the external link check for a conditional store |
| squash | input | 1 | Squash the held request |
| reqReady | output | 1 | No request is held |
| portSend | output | 1 | Send offered on the cache port |
| portCmd | output | 3 | Port command code (see R2) |
| portSeq | output | SEQ_W | Sequence number sent with the command |
| portAccept | input | 1 | Port takes the offered send |
| portRetry | input | 1 | Port may be tried again |
| rspValid | input | 1 | Port response for the pending request |
| doneValid | output | 1 | One-cycle completion strobe |
| doneSeq | output | SEQ_W | Sequence number of the completed request |
| doneScFail | output | 1 | Completion is a failed conditional store |
| memStall | output | 1 | Pending access has not yet returned |

## Verification
The embedded properties check, on every cycle, that no send is offered in the cycle after a refusal unless a retry arrived, and that a retry only arrives while the port is blocked. They also check that an accepted send is followed by neither a send nor a completion, that a completion never overlaps readiness or a stall, and that a failed conditional store completes straight after acceptance. The command mapping, the order of stall and wake-up, and the silent dropping of squashed responses are shown only by the bench's scenarios. The bench compares every output with its behavioural model on every cycle.

// File: rtl/cache_issue_pkg.sv
package cache_issue_pkg;

  typedef enum logic [2:0] {
    CMD_READ        = 3'd0,
    CMD_LOCKED_READ = 3'd1,
    CMD_WRITE       = 3'd2,
    CMD_SWAP        = 3'd3,
    CMD_COND_STORE  = 3'd4
  } portCmdE;

  typedef enum logic [2:0] {
    OP_FETCH    = 3'd0,
    OP_READ     = 3'd1,
    OP_WRITE    = 3'd2,
    OP_PREFETCH = 3'd3,
    OP_HINT     = 3'd4
  } reqOpE;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_PEND  = 2'd2,
    ST_DONE  = 2'd3
  } slotStateE;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;
    logic showDone;
  } ctlStrobeT;

endpackage

// File: rtl/cache_issue_dp.sv
module cache_issue_dp
  import cache_issue_pkg::*;
#(
  parameter int SEQ_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobeT        strobe,
  input  logic [2:0]       reqOp,
  input  logic             reqLock,
  input  logic             reqSwap,
  input  logic [SEQ_W-1:0] reqSeq,
  input  logic             linkOk,
  output logic             inImmediate,
  output logic             inScFail,
  output logic [2:0]       heldCmd,
  output logic [SEQ_W-1:0] heldSeq,
  output logic             scFailOut
);

  portCmdE          cmdNext;
  portCmdE          cmdReg;
  logic [SEQ_W-1:0] seqReg;
  logic             scFailReg;

  always_comb begin
    unique case (reqOp)
      OP_READ:  cmdNext = reqLock ? CMD_LOCKED_READ : CMD_READ;
      OP_WRITE: cmdNext = reqSwap ? CMD_SWAP
                        : (reqLock ? CMD_COND_STORE : CMD_WRITE);
      default:  cmdNext = CMD_READ;
    endcase
  end

  assign inScFail    = (reqOp == OP_WRITE) && reqLock && !reqSwap && !linkOk;
  assign inImmediate = (reqOp >= OP_PREFETCH) || inScFail;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg    <= CMD_READ;
      seqReg    <= '0;
      scFailReg <= 1'b0;
    end else if (strobe.latchReq) begin
      cmdReg    <= cmdNext;
      seqReg    <= reqSeq;
      scFailReg <= inScFail;
    end
  end

  assign heldCmd   = cmdReg;
  assign heldSeq   = seqReg;
  assign scFailOut = strobe.showDone && scFailReg;

endmodule

// File: rtl/cache_issue_fsm.sv
module cache_issue_fsm
  import cache_issue_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      inImmediate,
  input  logic      squash,
  input  logic      portAccept,
  input  logic      portRetry,
  input  logic      rspValid,
  output ctlStrobeT strobe,
  output logic      reqReady,
  output logic      portSend,
  output logic      doneValid,
  output logic      memStall
);

  slotStateE state;
  logic      blocked;
  logic      squashed;
  logic      stallReg;

  assign reqReady  = (state == ST_IDLE);
  assign portSend  = (state == ST_ISSUE) && !blocked;
  assign doneValid = (state == ST_DONE);
  assign memStall  = stallReg;

  assign strobe.latchReq = reqReady && reqValid;
  assign strobe.showDone = doneValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      squashed <= 1'b0;
      stallReg <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (reqValid) begin
          state    <= inImmediate ? ST_DONE : ST_ISSUE;
          squashed <= 1'b0;
        end
        ST_ISSUE: begin
          if (squash) state <= ST_IDLE;
          else if (portSend && portAccept) state <= ST_PEND;
        end
        ST_PEND: begin
          if (rspValid) begin
            state    <= squashed ? ST_IDLE : ST_DONE;
            squashed <= 1'b0;
            stallReg <= 1'b0;
          end else if (squash) begin
            squashed <= 1'b1;
            stallReg <= 1'b0;
          end else if (!squashed) begin
            stallReg <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) blocked <= 1'b0;
    else if (portRetry) blocked <= 1'b0;
    else if (portSend && !portAccept) blocked <= 1'b1;
  end

  // R3
  refused_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (portSend && !portAccept && !portRetry) |=> !portSend);

  // R4
  retry_blocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    portRetry |-> blocked);

  // R5
  accepted_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    (portSend && portAccept) |=> (!portSend && !doneValid));

  // R10
  done_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> (!reqReady && !memStall && !portSend));

endmodule

// File: rtl/cache_issue_ctl.sv
module cache_issue_ctl
  import cache_issue_pkg::*;
#(
  parameter int SEQ_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [2:0]       reqOp,
  input  logic             reqLock,
  input  logic             reqSwap,
  input  logic [SEQ_W-1:0] reqSeq,
  input  logic             linkOk,
  input  logic             squash,
  output logic             reqReady,
  output logic             portSend,
  output logic [2:0]       portCmd,
  output logic [SEQ_W-1:0] portSeq,
  input  logic             portAccept,
  input  logic             portRetry,
  input  logic             rspValid,
  output logic             doneValid,
  output logic [SEQ_W-1:0] doneSeq,
  output logic             doneScFail,
  output logic             memStall
);

  ctlStrobeT        strobe;
  logic             inImmediate;
  logic             inScFail;
  logic [SEQ_W-1:0] heldSeq;

  cache_issue_fsm u_fsm (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .inImmediate(inImmediate),
    .squash(squash), .portAccept(portAccept), .portRetry(portRetry),
    .rspValid(rspValid), .strobe(strobe), .reqReady(reqReady),
    .portSend(portSend), .doneValid(doneValid), .memStall(memStall)
  );

  cache_issue_dp #(.SEQ_W(SEQ_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqOp(reqOp),
    .reqLock(reqLock), .reqSwap(reqSwap), .reqSeq(reqSeq), .linkOk(linkOk),
    .inImmediate(inImmediate), .inScFail(inScFail), .heldCmd(portCmd),
    .heldSeq(heldSeq), .scFailOut(doneScFail)
  );

  assign portSeq = heldSeq;
  assign doneSeq = heldSeq;

  // R6
  scfail_direct_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && reqValid && inScFail) |=> (doneValid && doneScFail));

  // R8
  stall_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    memStall |-> (!reqReady && !portSend));

endmodule

// File: tb/cache_issue_ctl_test.sv
module cache_issue_ctl_test;

  localparam int SEQ_W = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             reqValid = 1'b0;
  logic [2:0]       reqOp = '0;
  logic             reqLock = 1'b0;
  logic             reqSwap = 1'b0;
  logic [SEQ_W-1:0] reqSeq = '0;
  logic             linkOk = 1'b0;
  logic             squash = 1'b0;
  logic             portAccept = 1'b0;
  logic             portRetry = 1'b0;
  logic             rspValid = 1'b0;
  logic             reqReady, portSend, doneValid, doneScFail, memStall;
  logic [2:0]       portCmd;
  logic [SEQ_W-1:0] portSeq, doneSeq;

  int checks = 0;
  int failures = 0;

  // model state: 0 idle, 1 trying to send, 2 waiting response, 3 completing
  int   mSt = 0;
  bit   mBlk = 0, mStall = 0, mSq = 0, mScF = 0;
  int   mSeq = 0, mCmd = 0;

  always #5 clk = ~clk;

  cache_issue_ctl #(.SEQ_W(SEQ_W)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqLock(reqLock), .reqSwap(reqSwap), .reqSeq(reqSeq), .linkOk(linkOk),
    .squash(squash), .reqReady(reqReady), .portSend(portSend),
    .portCmd(portCmd), .portSeq(portSeq), .portAccept(portAccept),
    .portRetry(portRetry), .rspValid(rspValid), .doneValid(doneValid),
    .doneSeq(doneSeq), .doneScFail(doneScFail), .memStall(memStall)
  );

  function automatic int expCmd(int op, bit lk, bit sw);
    if (op == 1) return lk ? 1 : 0;
    if (op == 2) return sw ? 3 : (lk ? 4 : 2);
    return 0;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic modelStep();
    int st = mSt;
    bit b = mBlk;
    bit sendNow = (st == 1) && !b;
    case (st)
      0: if (reqValid) begin
        mSeq = reqSeq;
        mCmd = expCmd(reqOp, reqLock, reqSwap);
        mScF = (reqOp == 2) && reqLock && !reqSwap && !linkOk;
        mSt  = (reqOp >= 3 || mScF) ? 3 : 1;
        mSq  = 0;
      end
      1: begin
        if (squash) mSt = 0;
        else if (sendNow && portAccept) mSt = 2;
      end
      2: begin
        if (rspValid) begin
          mSt = mSq ? 0 : 3; mSq = 0; mStall = 0;
        end else if (squash) begin
          mSq = 1; mStall = 0;
        end else if (!mSq) mStall = 1;
      end
      default: mSt = 0;
    endcase
    if (portRetry) mBlk = 0;
    else if (sendNow && !portAccept) mBlk = 1;
  endtask

  // one clock: update model, sample after edge, compare, clear pulses
  task automatic tick(string tag);
    modelStep();
    @(posedge clk);
    #1;
    check({tag, " reqReady"}, reqReady, mSt == 0);
    check({tag, " portSend"}, portSend, (mSt == 1) && !mBlk);
    check({tag, " doneValid"}, doneValid, mSt == 3);
    check({tag, " doneScFail"}, doneScFail, (mSt == 3) && mScF);
    check({tag, " memStall"}, memStall, mStall);
    if (mSt == 1 && !mBlk) begin
      check({tag, " portCmd"}, portCmd, mCmd);
      check({tag, " portSeq"}, portSeq, mSeq);
    end
    if (mSt == 3) check({tag, " doneSeq"}, doneSeq, mSeq);
    reqValid = 0; squash = 0; portAccept = 0; portRetry = 0; rspValid = 0;
  endtask

  task automatic offer(int op, bit lk, bit sw, bit ok, int seq);
    reqValid = 1; reqOp = 3'(op); reqLock = lk; reqSwap = sw;
    linkOk = ok; reqSeq = SEQ_W'(seq);
  endtask

  // plain pass through the port with a response delay
  task automatic simpleAccess(string tag, int op, bit lk, bit sw, int seq, int delay);
    offer(op, lk, sw, 1, seq); tick(tag);
    portAccept = 1; tick(tag);
    for (int i = 0; i < delay; i++) tick(tag);
    rspValid = 1; tick(tag);
    tick(tag);
  endtask

  initial begin
    #(20000 * 10);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    // R1: state after reset
    check("R1 reqReady", reqReady, 1);
    check("R1 portSend", portSend, 0);
    check("R1 doneValid", doneValid, 0);
    check("R1 memStall", memStall, 0);
    @(negedge clk);
    rstN = 1;
    tick("R1 idle");

    // R2: command mapping over each kind, R5/R8 on the way
    simpleAccess("R2 fetch", 0, 0, 0, 11, 0);
    simpleAccess("R2 read", 1, 0, 0, 12, 1);
    simpleAccess("R2 lockread", 1, 1, 0, 13, 0);
    simpleAccess("R2 write", 2, 0, 0, 14, 2);
    simpleAccess("R2 swap", 2, 1, 1, 15, 0);
    simpleAccess("R2 condstore", 2, 1, 0, 16, 1);

    // R8: long miss, stall held then cleared by the response
    simpleAccess("R8 stall", 1, 0, 0, 17, 4);

    // R3/R4: refusal, blocked window, retry, resend
    offer(2, 0, 0, 1, 20); tick("R3 take");
    portAccept = 0; tick("R3 refused");
    tick("R3 blocked");
    tick("R3 blocked");
    portRetry = 1; tick("R4 retry");
    portAccept = 0; tick("R3 refused again");
    portRetry = 1; tick("R4 retry2");
    portAccept = 1; tick("R4 resent");
    rspValid = 1; tick("R4 rsp");
    tick("R4 done");

    // R6: failed conditional store never touches the port
    offer(2, 1, 0, 0, 30); tick("R6 take");
    tick("R6 after");
    // passing conditional store goes to the port
    simpleAccess("R6 pass", 2, 1, 0, 31, 0);

    // R7: prefetch and hint
    offer(3, 0, 0, 1, 40); tick("R7 prefetch");
    tick("R7 after");
    offer(4, 1, 1, 0, 41); tick("R7 hint");
    tick("R7 after");

    // R9: squash before acceptance while blocked
    offer(1, 0, 0, 1, 50); tick("R9 take");
    portAccept = 0; tick("R9 refused");
    squash = 1; tick("R9 squash issue");
    portRetry = 1; tick("R9 retry");
    // R9: squash while pending, response dropped
    offer(1, 0, 0, 1, 51); tick("R9 take2");
    portAccept = 1; tick("R9 sent");
    tick("R9 stall");
    squash = 1; tick("R9 squash pend");
    tick("R9 wait");
    rspValid = 1; tick("R9 rsp dropped");
    tick("R9 ready");
    simpleAccess("R9 next", 0, 0, 0, 52, 0);

    // R10: requests while busy are ignored
    offer(1, 0, 0, 1, 60); tick("R10 take");
    offer(2, 0, 0, 1, 61); tick("R10 ignored");
    offer(2, 0, 0, 1, 62); portAccept = 1; tick("R10 ignored sent");
    offer(2, 0, 0, 1, 63); rspValid = 1; tick("R10 ignored rsp");
    tick("R10 done seq");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule